// File: doc/BRIEF.md
# SPI Flash Erase Sequencer

This block erases a region of an external SPI NOR flash, or the whole device, on behalf of a host. The host presents one request: an erase kind, a 24-bit byte address and a variant select that picks the alternate opcode where the device family needs it. The block then acts as SPI master. It sends a one-byte write-enable frame and releases chip select. It sends the erase frame, and then reads the status register in separate frames until the device no longer reports a write in progress.

The wait between status reads depends on the erase kind, because a sector clears in tens of milliseconds and a whole chip takes seconds. Each kind also has its own upper limit on total busy time. If the device is still busy at a poll after that limit, the block ends the operation with an error flag. All intervals and limits are parameters counted in clock cycles. The outcome is one `done` pulse, with `err` valid in the same cycle.

Top module: `spi_erase_seq`

## Requirements
- R1: After reset, and whenever no operation is running, `busy`=0, `done`=0, `cs_n`=1 and `sclk`=0.
- R2: Every accepted request first sends a frame holding only the byte 0x06, and `cs_n` goes high between that frame and the erase frame.
- R3: A sector erase (`req_type`=0) sends a 4-byte frame of 0x20 followed by address bits [23:16], [15:8] and [7:0]. No byte is read.
- R4: A block erase (`req_type`=1) sends the same 4-byte layout with opcode 0xD8 when `req_alt`=0, or 0x52 when `req_alt`=1.
- R5: A chip erase (`req_type`=2) sends a 1-byte frame, 0x60 when `req_alt`=0 or 0xC7 when `req_alt`=1, with no address.
- R6: The bus uses SPI mode 0. `sclk` is low whenever `cs_n` is high. `mosi` changes only while `sclk` is low. Bytes go most significant bit first, and `miso` is sampled on the rising edge.
- R7: After the erase frame, each poll is its own 2-byte frame: opcode 0x05, then one byte read from `miso`. Polling repeats while bit 0 of that byte is 1, and all other status bits have no effect.
- R8: Chip select stays high for at least the poll interval of the request's kind (sector, block or chip) before each status frame. It is high for no longer than that interval plus the chip-select gap plus 4 cycles.
- R9: When a status byte shows bit 0 clear, `done` pulses for exactly one cycle with `err`=0, and `busy` returns to 0 in that same cycle.
- R10: If bit 0 is still set at a poll that ends at least the kind's time limit after the erase frame ended, `done` pulses with `err`=1 and the block returns to idle.
- R11: A request presented while `busy`=1 is ignored. It sends no frame and does not change the running operation.
- R12: `req_type`=3 is not a valid kind. Such a request is ignored, and no frame is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_type | input | 2 | 0 sector, 1 block, 2 chip, 3 invalid |
| req_addr | input | 24 | Byte address for sector or block erase |
| req_alt | input | 1 | Selects the alternate opcode for block or chip erase |
| busy | output | 1 | High while an operation is running |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | Timeout flag, valid with done |
| sclk | output | 1 | SPI clock, mode 0 |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data to the device |
| miso | input | 1 | SPI data from the device |

## Verification
`done` is registered in the last cycle of the chip-select gap that follows the final status frame. It therefore lands the gap length plus at most three cycles after `cs_n` rises. The bench timestamps every `cs_n` edge and checks `done` against that window. The high time of `cs_n` before each status frame must fall between the kind's poll interval and that interval plus the gap plus four cycles. A timeout must come no earlier than the kind's limit after the erase frame ends. The bench samples outputs one nanosecond after the clock edge. It decodes frames from `sclk`/`mosi` edges, so each result is read only after the register that produces it has updated.

// File: rtl/spi_erase_pkg.sv
package spi_erase_pkg;

  typedef enum logic [1:0] {
    EK_SECTOR = 2'd0,
    EK_BLOCK  = 2'd1,
    EK_CHIP   = 2'd2,
    EK_RSVD   = 2'd3
  } erase_kind_e;

  typedef enum logic [1:0] {
    FR_WREN   = 2'd0,
    FR_ERASE  = 2'd1,
    FR_STATUS = 2'd2
  } frame_e;

  localparam logic [7:0] OP_WREN    = 8'h06;
  localparam logic [7:0] OP_RDSR    = 8'h05;
  localparam logic [7:0] OP_SECT    = 8'h20;
  localparam logic [7:0] OP_BLK     = 8'hD8;
  localparam logic [7:0] OP_BLK_ALT = 8'h52;
  localparam logic [7:0] OP_CHIP    = 8'h60;
  localparam logic [7:0] OP_CHIP_ALT = 8'hC7;
  localparam int         WIP_POS    = 0;

  function automatic logic [7:0] erase_opcode(input erase_kind_e k, input logic alt);
    case (k)
      EK_SECTOR: erase_opcode = OP_SECT;
      EK_BLOCK:  erase_opcode = alt ? OP_BLK_ALT : OP_BLK;
      default:   erase_opcode = alt ? OP_CHIP_ALT : OP_CHIP;
    endcase
  endfunction

  function automatic logic [2:0] frame_len(input frame_e f, input erase_kind_e k);
    case (f)
      FR_WREN:   frame_len = 3'd1;
      FR_STATUS: frame_len = 3'd2;
      default:   frame_len = (k == EK_CHIP) ? 3'd1 : 3'd4;
    endcase
  endfunction

  function automatic logic [7:0] frame_byte(input frame_e f, input logic [1:0] idx,
                                            input logic [7:0] op, input logic [23:0] a);
    case (f)
      FR_WREN:   frame_byte = OP_WREN;
      FR_STATUS: frame_byte = (idx == 2'd0) ? OP_RDSR : 8'h00;
      default: begin
        case (idx)
          2'd0:    frame_byte = op;
          2'd1:    frame_byte = a[23:16];
          2'd2:    frame_byte = a[15:8];
          default: frame_byte = a[7:0];
        endcase
      end
    endcase
  endfunction

endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int HALF = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic [7:0] rx_byte,
  output logic       byte_done
);
  localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF - 1);

  logic          active;
  logic [DW-1:0] div_cnt;
  logic [3:0]    edge_cnt;
  logic [7:0]    sh_tx;
  logic [7:0]    sh_rx;
  logic          tick;

  assign tick = active && (div_cnt == DIV_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      div_cnt   <= '0;
      edge_cnt  <= '0;
      sh_tx     <= '0;
      sh_rx     <= '0;
      sclk      <= 1'b0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (start && !active) begin
        active   <= 1'b1;
        div_cnt  <= '0;
        edge_cnt <= '0;
        sh_tx    <= tx_byte;
        sclk     <= 1'b0;
      end else if (active) begin
        if (tick) begin
          div_cnt  <= '0;
          sclk     <= ~sclk;
          edge_cnt <= edge_cnt + 4'd1;
          if (!sclk) begin
            sh_rx <= {sh_rx[6:0], miso};
          end else begin
            sh_tx <= {sh_tx[6:0], 1'b0};
            if (edge_cnt == 4'd15) begin
              active    <= 1'b0;
              byte_done <= 1'b1;
            end
          end
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end
    end
  end

  assign mosi    = active ? sh_tx[7] : 1'b0;
  assign rx_byte = sh_rx;

  // R6
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R6
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !sclk);

endmodule

// File: rtl/erase_interval_timer.sv
module erase_interval_timer #(
  parameter int TW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [TW-1:0] limit,
  output logic          reached
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (cnt != {TW{1'b1}}) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign reached = (cnt >= (limit - TW'(1)));

  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> (cnt == '0));

endmodule

// File: rtl/spi_erase_seq.sv
module spi_erase_seq
  import spi_erase_pkg::*;
#(
  parameter int              CLK_DIV     = 4,
  parameter int              CS_GAP      = 4,
  parameter int              TW          = 36,
  parameter longint unsigned POLL_SECTOR = 64'd1_000_000,
  parameter longint unsigned POLL_BLOCK  = 64'd10_000_000,
  parameter longint unsigned POLL_CHIP   = 64'd100_000_000,
  parameter longint unsigned TMO_SECTOR  = 64'd100_000_000,
  parameter longint unsigned TMO_BLOCK   = 64'd500_000_000,
  parameter longint unsigned TMO_CHIP    = 64'd10_000_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_type,
  input  logic [23:0] req_addr,
  input  logic        req_alt,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic        sclk,
  output logic        cs_n,
  output logic        mosi,
  input  logic        miso
);
  localparam int GW = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;
  localparam logic [GW-1:0] GAP_LAST = GW'(CS_GAP - 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_SHIFT, ST_GAP, ST_WAIT
  } state_e;

  state_e       state;
  frame_e       frame;
  erase_kind_e  kind;
  logic         alt_q;
  logic [23:0]  addr_q;
  logic [1:0]   byte_idx;
  logic [GW-1:0] gap_cnt;
  logic         cs_n_q, done_q, err_q, wren_seen;

  logic         accept, start_pulse, byte_done, gap_end, frame_last;
  logic         status_wip, poll_due, tmo_hit;
  logic [7:0]   rx_byte, tx_byte;
  logic [TW-1:0] poll_limit, tmo_limit;

  assign accept      = (state == ST_IDLE) && req_valid && (erase_kind_e'(req_type) != EK_RSVD);
  assign start_pulse = (state == ST_LOAD);
  assign tx_byte     = frame_byte(frame, byte_idx, erase_opcode(kind, alt_q), addr_q);
  assign frame_last  = ({1'b0, byte_idx} == (frame_len(frame, kind) - 3'd1));
  assign gap_end     = (state == ST_GAP) && (gap_cnt == GAP_LAST);
  assign status_wip  = rx_byte[WIP_POS];

  always_comb begin
    case (kind)
      EK_SECTOR: begin poll_limit = TW'(POLL_SECTOR); tmo_limit = TW'(TMO_SECTOR); end
      EK_BLOCK:  begin poll_limit = TW'(POLL_BLOCK);  tmo_limit = TW'(TMO_BLOCK);  end
      default:   begin poll_limit = TW'(POLL_CHIP);   tmo_limit = TW'(TMO_CHIP);   end
    endcase
  end

  spi_byte_shifter #(.HALF(CLK_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start_pulse), .tx_byte(tx_byte), .miso(miso),
    .sclk(sclk), .mosi(mosi), .rx_byte(rx_byte), .byte_done(byte_done)
  );

  erase_interval_timer #(.TW(TW)) u_poll_tmr (
    .clk(clk), .rst_n(rst_n), .clr(state != ST_WAIT), .limit(poll_limit), .reached(poll_due)
  );

  erase_interval_timer #(.TW(TW)) u_busy_tmr (
    .clk(clk), .rst_n(rst_n), .clr((state == ST_GAP) && (frame == FR_ERASE)),
    .limit(tmo_limit), .reached(tmo_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      frame     <= FR_WREN;
      kind      <= EK_SECTOR;
      alt_q     <= 1'b0;
      addr_q    <= '0;
      byte_idx  <= '0;
      gap_cnt   <= '0;
      cs_n_q    <= 1'b1;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      wren_seen <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            kind      <= erase_kind_e'(req_type);
            alt_q     <= req_alt;
            addr_q    <= req_addr;
            frame     <= FR_WREN;
            byte_idx  <= '0;
            cs_n_q    <= 1'b0;
            wren_seen <= 1'b0;
            state     <= ST_LOAD;
          end
        end
        ST_LOAD: state <= ST_SHIFT;
        ST_SHIFT: begin
          if (byte_done) begin
            if (frame_last) begin
              cs_n_q  <= 1'b1;
              gap_cnt <= '0;
              state   <= ST_GAP;
            end else begin
              byte_idx <= byte_idx + 2'd1;
              state    <= ST_LOAD;
            end
          end
        end
        ST_GAP: begin
          if (gap_end) begin
            case (frame)
              FR_WREN: begin
                wren_seen <= 1'b1;
                frame     <= FR_ERASE;
                byte_idx  <= '0;
                cs_n_q    <= 1'b0;
                state     <= ST_LOAD;
              end
              FR_ERASE: state <= ST_WAIT;
              default: begin
                if (!status_wip) begin
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
                end else if (tmo_hit) begin
                  done_q <= 1'b1;
                  err_q  <= 1'b1;
                  state  <= ST_IDLE;
                end else begin
                  state <= ST_WAIT;
                end
              end
            endcase
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        ST_WAIT: begin
          if (poll_due) begin
            frame    <= FR_STATUS;
            byte_idx <= '0;
            cs_n_q   <= 1'b0;
            state    <= ST_LOAD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = done_q;
  assign err  = err_q;
  assign cs_n = cs_n_q;

  // R1
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !sclk));

  // R2
  wren_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse && frame == FR_ERASE && byte_idx == 2'd0) |-> wren_seen);

  // R6
  cs_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (done && !busy));

  // R11
  accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(req_valid) && $past(req_type) != 2'd3));

endmodule

// File: tb/tb_spi_erase_seq.sv
`timescale 1ns/1ps
module tb_spi_erase_seq;
  localparam int P_SEC = 40, P_BLK = 80, P_CHP = 160;
  localparam int T_SEC = 600, T_BLK = 1500, T_CHP = 3000;
  localparam int GAP = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_alt = 1'b0;
  logic [1:0] req_type = 2'd0;
  logic [23:0] req_addr = '0;
  logic busy, done, err, sclk, cs_n, mosi;
  logic miso = 1'b0;

  always #5 clk = ~clk;

  spi_erase_seq #(
    .CLK_DIV(2), .CS_GAP(GAP), .TW(36),
    .POLL_SECTOR(P_SEC), .POLL_BLOCK(P_BLK), .POLL_CHIP(P_CHP),
    .TMO_SECTOR(T_SEC), .TMO_BLOCK(T_BLK), .TMO_CHIP(T_CHP)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
    .req_addr(req_addr), .req_alt(req_alt), .busy(busy), .done(done), .err(err),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  int errors = 0, checks = 0, cyc = 0;
  bit finished = 1'b0;

  // device model
  logic [7:0] fr_b [64][4];
  int fr_len [64], fr_s [64], fr_e [64];
  int nfr = 0, bitcnt = 0, busy_left = 0, mode_bad = 0;
  bit open_fr = 1'b0;
  logic [7:0] sh = '0;
  logic [7:0] stat_v;

  assign stat_v = (busy_left > 0) ? 8'h03 : 8'h02;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge cs_n) begin
    open_fr = 1'b1; bitcnt = 0;
    if (nfr < 64) begin fr_s[nfr] = cyc; for (int i = 0; i < 4; i++) fr_b[nfr][i] = 8'h00; end
  end

  always @(posedge sclk) begin
    if (cs_n) mode_bad++;
    if (open_fr && nfr < 64) begin
      sh = {sh[6:0], mosi};
      bitcnt++;
      if (bitcnt % 8 == 0 && bitcnt <= 32) fr_b[nfr][bitcnt/8 - 1] = sh;
    end
  end

  always @(negedge sclk) begin
    if (open_fr && nfr < 64 && bitcnt >= 8 && bitcnt < 16 && fr_b[nfr][0] == 8'h05)
      miso = stat_v[15 - bitcnt];
  end

  always @(mosi) if (open_fr && sclk) mode_bad++;

  always @(posedge cs_n) begin
    if (open_fr) begin
      open_fr = 1'b0; miso = 1'b0;
      if (nfr < 64) begin
        fr_len[nfr] = bitcnt / 8; fr_e[nfr] = cyc;
        if (fr_b[nfr][0] == 8'h05 && busy_left > 0) busy_left--;
        nfr++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] want_op(input logic [1:0] t, input logic a);
    if (t == 2'd0) return 8'h20;
    if (t == 2'd1) return a ? 8'h52 : 8'hD8;
    return a ? 8'hC7 : 8'h60;
  endfunction

  task automatic wait_done(output int dcyc, output logic derr, output logic dbusy);
    dcyc = -1; derr = 1'b0; dbusy = 1'b1;
    for (int n = 0; n < 30000; n++) begin
      @(posedge clk); #1;
      if (done) begin dcyc = cyc; derr = err; dbusy = busy; return; end
    end
  endtask

  task automatic send_req(input logic [1:0] t, input logic [23:0] a, input logic alt);
    @(negedge clk);
    req_valid = 1'b1; req_type = t; req_addr = a; req_alt = alt;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_erase(input logic [1:0] t, input logic [23:0] a, input logic alt,
                           input int polls, input bit exp_err, input string req);
    int dcyc, pint, tmo, nstat, last;
    logic derr, dbusy;
    pint = (t == 0) ? P_SEC : (t == 1) ? P_BLK : P_CHP;
    tmo  = (t == 0) ? T_SEC : (t == 1) ? T_BLK : T_CHP;
    nfr = 0; busy_left = polls;
    send_req(t, a, alt);
    wait_done(dcyc, derr, dbusy);
    chk(dcyc >= 0, "R9", "done seen", dcyc, 1);
    if (dcyc < 0) return;
    chk(derr == exp_err, exp_err ? "R10" : "R9", "err at done", derr, exp_err);
    chk(dbusy == 1'b0, "R9", "busy at done", dbusy, 0);
    // R2 write-enable frame first
    chk(fr_len[0] == 1 && fr_b[0][0] == 8'h06, "R2", "wren frame", fr_b[0][0], 8'h06);
    chk(fr_s[1] > fr_e[0], "R2", "cs released before erase", fr_s[1], fr_e[0] + 1);
    // R3 R4 R5 erase frame
    chk(fr_b[1][0] == want_op(t, alt), req, "erase opcode", fr_b[1][0], want_op(t, alt));
    chk(fr_len[1] == ((t == 2) ? 1 : 4), req, "erase frame length", fr_len[1], (t == 2) ? 1 : 4);
    if (t != 2)
      chk({fr_b[1][1], fr_b[1][2], fr_b[1][3]} == a, req, "address bytes",
          {fr_b[1][1], fr_b[1][2], fr_b[1][3]}, a);
    nstat = nfr - 2;
    if (!exp_err) chk(nstat == polls + 1, "R7", "status frame count", nstat, polls + 1);
    for (int i = 2; i < nfr && i < 64; i++) begin
      chk(fr_len[i] == 2 && fr_b[i][0] == 8'h05, "R7", "status frame", fr_b[i][0], 8'h05);
      chk(fr_s[i] - fr_e[i-1] >= pint && fr_s[i] - fr_e[i-1] <= pint + GAP + 4,
          "R8", "poll spacing", fr_s[i] - fr_e[i-1], pint);
    end
    last = (nfr < 64) ? nfr - 1 : 63;
    chk(dcyc - fr_e[last] <= GAP + 3 && dcyc > fr_e[last], "R9", "done after last frame",
        dcyc - fr_e[last], GAP);
    if (exp_err) begin
      chk(dcyc - fr_e[1] >= tmo, "R10", "timeout elapsed", dcyc - fr_e[1], tmo);
      chk(busy_left > 0, "R10", "device still busy", busy_left, 1);
    end
  endtask

  task automatic test_reset();
    chk(busy == 0 && done == 0, "R1", "busy/done after reset", {busy, done}, 0);
    chk(cs_n == 1 && sclk == 0, "R1", "bus idle after reset", {cs_n, sclk}, 2);
  endtask

  task automatic test_ignore_busy();
    int dcyc, cnt;
    logic derr, dbusy;
    nfr = 0; busy_left = 2;
    send_req(2'd1, 24'h123456, 1'b0);
    repeat (20) @(negedge clk);
    send_req(2'd2, 24'h000000, 1'b1);
    wait_done(dcyc, derr, dbusy);
    chk(fr_b[1][0] == 8'hD8, "R11", "running opcode kept", fr_b[1][0], 8'hD8);
    chk({fr_b[1][1], fr_b[1][2], fr_b[1][3]} == 24'h123456, "R11", "running address kept",
        {fr_b[1][1], fr_b[1][2], fr_b[1][3]}, 24'h123456);
    cnt = nfr;
    repeat (300) @(negedge clk);
    chk(nfr == cnt && busy == 0, "R11", "no frame after done", nfr, cnt);
  endtask

  task automatic test_reserved();
    nfr = 0;
    send_req(2'd3, 24'hABCDEF, 1'b0);
    repeat (100) @(negedge clk);
    chk(nfr == 0, "R12", "frames for type 3", nfr, 0);
    chk(busy == 0 && cs_n == 1, "R12", "stays idle", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    run_erase(2'd0, 24'hA5C30F, 1'b0, 3, 1'b0, "R3");
    run_erase(2'd0, 24'h00FF80, 1'b1, 0, 1'b0, "R3");
    run_erase(2'd1, 24'h7E0001, 1'b0, 2, 1'b0, "R4");
    run_erase(2'd1, 24'hFFFFFF, 1'b1, 1, 1'b0, "R4");
    run_erase(2'd2, 24'h123456, 1'b0, 2, 1'b0, "R5");
    run_erase(2'd2, 24'h000000, 1'b1, 0, 1'b0, "R5");
    run_erase(2'd0, 24'h010203, 1'b0, 1000, 1'b1, "R3");
    run_erase(2'd1, 24'h040506, 1'b0, 1000, 1'b1, "R4");
    test_ignore_busy();
    test_reserved();
    run_erase(2'd0, 24'h800000, 1'b0, 1, 1'b0, "R3");
    chk(mode_bad == 0, "R6", "mode 0 violations", mode_bad, 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule